// File: doc/BRIEF.md
# Bus Parity Generator for a Multiplexed 64-bit Address/Data Bus

This block produces the even-parity bits that accompany a multiplexed address/data bus. The bus is split into lanes of 32 data bits, and each lane has four active-low command/byte-enable bits. For every lane the block computes one parity bit over that lane's data bits and enable bits. It registers the result, so each parity bit appears on the clock after the bus values it covers. Each parity bit has its own output enable, so the pin can be tri-stated when this device must not drive it.

The bus sequencer supplies plain control inputs: an address-phase strobe, a data-phase flag, the active-low initiator-ready and target-ready strobes, the transfer direction, the device's role, and whether the bus is in wide (64-bit) mode. From these inputs the block decides on each clock whether this device owns the parity for the current lanes. As initiator it owns the parity for address phases and for write data. As target it owns the parity for read data only. In narrow mode the upper lane takes no part.

None of the edges needs valid/ready handshaking. The bus values and strobes are sampled on every clock, and the block can never stall, so it applies no back-pressure.

Top module: `pci_parity_gen`

## Requirements
- R1: The lane-0 parity output equals the XOR of ad[31:0] and cbe_n[3:0] as sampled one clock earlier. The ones among those 36 bits plus the parity bit therefore make an even count.
- R2: The lane-1 parity output is the XOR of ad[63:32] and cbe_n[7:4] as sampled one clock earlier, whenever lane 1 is qualified.
- R3: When master_role=1 and addr_phase=1, both output enables are high on the next clock when wide_bus=1. Only par_oe[0] is high when wide_bus=0.
- R4: When master_role=1, write_xfer=1 and data_phase=1, the enables rise one clock after a clock with irdy_n=0. While irdy_n=1 (initiator wait) the enables stay low.
- R5: When master_role=0, write_xfer=0 and data_phase=1, the enables rise one clock after a clock with trdy_n=0. While trdy_n=1 they stay low.
- R6: No enable is raised for an initiator read data phase, a target write data phase, or an address phase seen as target.
- R7: When wide_bus=0, par_oe[1] stays 0 and par[1] keeps its previous value.
- R8: On a clock where a lane is not qualified, its parity output keeps the value it last held.
- R9: On the clock after the completion clock (irdy_n=0 and trdy_n=0), the enables are still high. They fall on the clock after the phase qualification ends.
- R10: Reset (rst_n=0, asynchronous) clears both parity bits and both enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad | input | 64 | Multiplexed address/data lanes (lane 0 = bits 31:0) |
| cbe_n | input | 8 | Active-low command/byte enables (lane 0 = bits 3:0) |
| addr_phase | input | 1 | High on the clock where the transaction's address is on the bus |
| data_phase | input | 1 | High while the transaction is in a data phase |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| write_xfer | input | 1 | 1 = write transfer, 0 = read transfer |
| master_role | input | 1 | 1 = this device is the initiator, 0 = target |
| wide_bus | input | 1 | 1 = 64-bit bus, 0 = 32-bit bus (upper lane idle) |
| par | output | 2 | Registered parity per lane |
| par_oe | output | 2 | Output enable per lane parity bit |

## Verification
The bench builds the block with its defaults: two lanes of 32 data bits and four enables each. With two lanes, the narrow-bus gating of the upper lane is reachable, and so is the separate hold behaviour of each lane. A single-lane build would leave the upper-lane gating out of reach. The bench keeps its own per-lane model of the last qualified parity value. This lets it check the held value on quiet clocks, in addition to the freshly computed value.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  localparam int unsigned DEF_LANES  = 2;
  localparam int unsigned DEF_LANE_W = 32;
  localparam int unsigned DEF_BE_W   = 4;

  typedef struct packed {
    logic addr_phase;
    logic data_phase;
    logic irdy_n;
    logic trdy_n;
    logic write_xfer;
    logic master_role;
  } phase_ctl_t;
endpackage

// File: rtl/pci_par_drive_ctrl.sv
module pci_par_drive_ctrl
  import pci_par_pkg::*;
(
  input  phase_ctl_t ctl,
  output logic       own_now
);
  logic addr_own, wr_own, rd_own;

  always_comb begin
    addr_own = ctl.addr_phase & ctl.master_role;
    wr_own   = ctl.data_phase & ctl.master_role & ctl.write_xfer & ~ctl.irdy_n;
    rd_own   = ctl.data_phase & ~ctl.master_role & ~ctl.write_xfer & ~ctl.trdy_n;
    own_now  = addr_own | wr_own | rd_own;
  end
endmodule

// File: rtl/pci_par_lane.sv
module pci_par_lane #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] lane_data,
  input  logic [BE_W-1:0]   lane_be_n,
  input  logic              capture,
  input  logic              lane_en,
  output logic              par_q,
  output logic              oe_q
);
  localparam int unsigned COV_W = LANE_W + BE_W;

  logic [COV_W-1:0] covered;
  logic             take;

  assign covered = {lane_be_n, lane_data};
  assign take    = capture & lane_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= take;
      if (take) par_q <= ^covered;
    end
  end

  // R1
  even_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (($countones({$past(covered), par_q}) % 2) == 0));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(par_q));

  // R7
  lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_en |=> !oe_q);
endmodule

// File: rtl/pci_parity_gen.sv
module pci_parity_gen
  import pci_par_pkg::*;
#(
  parameter int unsigned NUM_LANES = DEF_LANES,
  parameter int unsigned LANE_W    = DEF_LANE_W,
  parameter int unsigned BE_W      = DEF_BE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LANES*LANE_W-1:0]   ad,
  input  logic [NUM_LANES*BE_W-1:0]     cbe_n,
  input  logic                          addr_phase,
  input  logic                          data_phase,
  input  logic                          irdy_n,
  input  logic                          trdy_n,
  input  logic                          write_xfer,
  input  logic                          master_role,
  input  logic                          wide_bus,
  output logic [NUM_LANES-1:0]          par,
  output logic [NUM_LANES-1:0]          par_oe
);
  phase_ctl_t ctl;
  logic       own_now;

  assign ctl = '{addr_phase: addr_phase, data_phase: data_phase,
                 irdy_n: irdy_n, trdy_n: trdy_n,
                 write_xfer: write_xfer, master_role: master_role};

  pci_par_drive_ctrl u_ctrl (
    .ctl     (ctl),
    .own_now (own_now)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic en;
    assign en = (i == 0) ? 1'b1 : wide_bus;

    pci_par_lane #(.LANE_W(LANE_W), .BE_W(BE_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_data (ad[i*LANE_W +: LANE_W]),
      .lane_be_n (cbe_n[i*BE_W +: BE_W]),
      .capture   (own_now),
      .lane_en   (en),
      .par_q     (par[i]),
      .oe_q      (par_oe[i])
    );
  end

  // R6
  no_target_write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_role && write_xfer) |=> (par_oe == '0));

  // R6
  no_initiator_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_role && !write_xfer && !addr_phase) |=> (par_oe == '0));

  // R3
  initiator_addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_role && addr_phase) |=> par_oe[0]);

  // R4
  initiator_wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_role && write_xfer && irdy_n && !addr_phase) |=> (par_oe == '0));
endmodule

// File: tb/tb_pci_parity_gen.sv
module tb_pci_parity_gen;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] ad;
  logic [7:0]  cbe_n;
  logic        addr_phase, data_phase, irdy_n, trdy_n;
  logic        write_xfer, master_role, wide_bus;
  logic [1:0]  par, par_oe;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  logic [1:0]  exp_par;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_parity_gen dut (
    .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n),
    .addr_phase(addr_phase), .data_phase(data_phase),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .write_xfer(write_xfer),
    .master_role(master_role), .wide_bus(wide_bus),
    .par(par), .par_oe(par_oe)
  );

  // control field order: {addr_phase, data_phase, irdy_n, trdy_n, write_xfer, master_role, wide_bus}
  typedef struct packed {
    logic [63:0] ad;
    logic [7:0]  cbe_n;
    logic [6:0]  ctl;
    logic [1:0]  exp_oe;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    {64'h0000_0001_0000_0003, 8'h7E, 7'b1_0_1_1_1_1_1, 2'b11}, // R3 initiator address, wide
    {64'hFFFF_0000_1234_5678, 8'h00, 7'b0_1_1_1_1_1_1, 2'b00}, // R4 wait, R8 hold
    {64'hDEAD_BEEF_0F0F_0F0F, 8'h35, 7'b0_1_0_1_1_1_1, 2'b11}, // R4 irdy asserted, R1 R2
    {64'h8000_0000_0000_0001, 8'h10, 7'b0_1_0_0_1_1_1, 2'b11}, // R9 completion clock
    {64'h1111_1111_1111_1111, 8'hFF, 7'b0_0_1_1_1_1_1, 2'b00}, // R9 drop after phase, R8
    {64'hA5A5_A5A5_5A5A_5A5A, 8'hC3, 7'b0_1_0_0_0_0_1, 2'b11}, // R5 target read
    {64'h0123_4567_89AB_CDEF, 8'h01, 7'b0_1_0_1_0_0_1, 2'b00}, // R5 target wait
    {64'hFEDC_BA98_7654_3210, 8'h80, 7'b0_1_0_0_0_1_1, 2'b00}, // R6 initiator read
    {64'h0000_FFFF_0000_FFFF, 8'h0F, 7'b0_1_0_0_1_0_1, 2'b00}, // R6 target write
    {64'h7777_0000_0000_7777, 8'h66, 7'b1_0_1_1_1_0_1, 2'b00}, // R6 target address
    {64'h0F00_0000_0000_00F1, 8'h9B, 7'b1_0_1_1_1_1_0, 2'b01}, // R7 narrow address
    {64'hFFFF_FFFF_0000_0007, 8'hF2, 7'b0_1_0_1_1_1_0, 2'b01}, // R7 narrow write
    {64'h1357_9BDF_2468_ACE0, 8'h5C, 7'b0_1_0_1_1_1_1, 2'b11}  // R1 R2 wide write
  };

  task automatic check(input string req, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic set_idle();
    ad = '0; cbe_n = '1; addr_phase = 0; data_phase = 0;
    irdy_n = 1; trdy_n = 1; write_xfer = 0; master_role = 0; wide_bus = 1;
  endtask

  task automatic apply(input vec_t v, input string req);
    logic [1:0] e;
    ad = v.ad; cbe_n = v.cbe_n;
    {addr_phase, data_phase, irdy_n, trdy_n, write_xfer, master_role, wide_bus} = v.ctl;
    e = exp_par;
    if (v.exp_oe[0]) e[0] = ^{v.ad[31:0], v.cbe_n[3:0]};
    if (v.exp_oe[1]) e[1] = ^{v.ad[63:32], v.cbe_n[7:4]};
    @(negedge clk);
    check(req, "par_oe", par_oe, v.exp_oe);
    check(req, "par", par, e);
    exp_par = e;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    set_idle();
    rst_n = 0;
    exp_par = '0;
    repeat (2) @(negedge clk);
    check("R10", "reset oe", par_oe, 2'b00);
    check("R10", "reset par", par, 2'b00);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) apply(VECS[i], "vector");

    // R1 corner: all ones over 36 bits gives even count -> parity 0
    apply({64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 7'b1_0_1_1_1_1_1, 2'b11}, "R1 all-ones");
    check("R1", "all-ones value", par, 2'b00);
    // R2 corner: single set bit in the upper lane only -> upper parity 1, lower 0
    apply({64'h0000_0001_0000_0000, 8'h00, 7'b1_0_1_1_1_1_1, 2'b11}, "R2 single-bit");
    check("R2", "single-bit value", par, 2'b10);
    // R7: narrow mode keeps upper value 1 while lower changes
    apply({64'h0000_0000_0000_0001, 8'h00, 7'b1_0_1_1_1_1_0, 2'b01}, "R7 hold-upper");
    check("R7", "upper held", par, 2'b11);

    // R10: mid-run reset clears state
    rst_n = 0;
    #1;
    check("R10", "async reset oe", par_oe, 2'b00);
    check("R10", "async reset par", par, 2'b00);
    exp_par = '0;
    @(negedge clk);
    rst_n = 1;
    set_idle();
    @(negedge clk);
    check("R10", "idle after reset", par_oe, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule